// File: doc/BRIEF.md
# External Interrupt Request Register Unit

This unit gathers external interrupt requests for one processor. Any bus master, such as the system I/O controller or another processor raising an interprocessor interrupt, posts an interrupt by writing an interrupt number to a single memory-mapped word. The unit turns that number into one pending bit. Numbering runs from the most significant end, so number 0 sets the top bit of the pending word. A bus read of the same word returns the pending word.

The processor reaches the unit through a control-register port. The port has a write enable, a one-bit register select, write data, and read-back buses for the pending word and the enable mask. Writing the pending word acknowledges interrupts with write-one-to-clear semantics. Writing the mask replaces the mask. The unit drives one registered, level-sensitive request to the core. The request is high exactly when a pending bit is also enabled.

The bus side is handled by a three-state response machine. `BUS_IDLE` is the state with no response in flight. From any state, a request with a legal size moves the machine to `BUS_ACK`. A request with an illegal size moves it to `BUS_REJECT`. A cycle with no request returns it to `BUS_IDLE`. Each of `BUS_ACK` and `BUS_REJECT` presents its response for one cycle.

Top module: `ext_irq_unit`

## Requirements
- R1: A synchronous active-high reset clears the pending word, the enable mask and the request output.
- R2: A bus write with size code 2 (4 bytes) takes the interrupt number from the low 6 bits of the write data and sets pending bit 63 minus that number. Number 0 sets bit 63 and number 63 sets bit 0.
- R3: A bus write never clears a pending bit, and the write-data bits above bit 5 have no effect.
- R4: A bus read with size code 2 answers in the next cycle with `bus_rsp_valid`=1, `bus_rsp_err`=0 and `bus_rdata` equal to the pending word at the request cycle.
- R5: A bus request with any size code other than 2 is rejected. The next cycle shows `bus_rsp_valid`=1, `bus_rsp_err`=1 and `bus_rdata`=0, and the pending word does not change.
- R6: A processor write with `cpu_sel`=0 clears each pending bit where `cpu_wdata` is 1 and keeps the other pending bits.
- R7: A processor write with `cpu_sel`=1 replaces the whole enable mask with `cpu_wdata`.
- R8: After each clock edge, `irq_req` equals the OR-reduction of (pending AND mask) as it stands after that edge. The request therefore follows every bus set, pending clear and mask write with no further delay.
- R9: When a bus set and a processor clear hit the same bit in the same cycle, the bit ends up set.
- R10: Every bus request produces exactly one response cycle, in the cycle after the request. `bus_rsp_valid` is 0 after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request present this cycle |
| bus_write | input | 1 | 1 = write (post interrupt), 0 = read |
| bus_size | input | 2 | Access size code: 0=1B, 1=2B, 2=4B, 3=8B |
| bus_wdata | input | 32 | Bus write data; the low 6 bits are the interrupt number |
| bus_rsp_valid | output | 1 | Response cycle |
| bus_rsp_err | output | 1 | Response is a rejection |
| bus_rdata | output | 64 | Read data (pending word) |
| cpu_we | input | 1 | Processor register write enable |
| cpu_sel | input | 1 | 0 = pending (write-one-to-clear), 1 = enable mask |
| cpu_wdata | input | 64 | Processor write data |
| cpu_pend | output | 64 | Current pending word |
| cpu_mask | output | 64 | Current enable mask |
| irq_req | output | 1 | Level interrupt request to the core |

## Verification
The bench posts interrupt numbers 0 and 63 and a number with junk in the upper data bits. A design with forward bit order, or one that uses the full data word, would set the wrong bit or none at all. It issues accesses with illegal sizes, both writes and reads, which would corrupt the pending word or return stale data if the size check were missing. It drives a bus set and a processor clear on the same bit in one cycle, where a design giving the clear priority would lose the interrupt. It follows the request output through mask writes and acknowledges, so a design that ignores the mask, or lags by an extra cycle, reports a wrong level.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_ACK    = 2'd1,
        BUS_REJECT = 2'd2
    } bus_st_e;

    localparam logic [1:0] SZ_WORD  = 2'd2;
    localparam logic       SEL_PEND = 1'b0;
    localparam logic       SEL_MASK = 1'b1;

endpackage

// File: rtl/eir_bus_port.sv
module eir_bus_port
    import ext_irq_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int BUS_DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic [WORD_W-1:0] pend_q,
    output logic              bus_rsp_valid,
    output logic              bus_rsp_err,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [WORD_W-1:0] set_vec
);
    localparam int LOG_W = $clog2(WORD_W);

    bus_st_e           state_q, state_d;
    logic [WORD_W-1:0] rdata_q;
    logic              size_ok;
    logic              post_hit;
    logic [LOG_W-1:0]  irq_num;
    logic              unused_hi;

    assign size_ok   = (bus_size == SZ_WORD);
    assign post_hit  = bus_valid && bus_write && size_ok;
    assign irq_num   = bus_wdata[LOG_W-1:0];
    assign unused_hi = ^bus_wdata[BUS_DW-1:LOG_W];

    // Reverse-order decode: number n selects bit WORD_W-1-n
    for (genvar i = 0; i < WORD_W; i++) begin : g_dec
        assign set_vec[i] = post_hit && (irq_num == LOG_W'(WORD_W - 1 - i));
    end

    // Next-state logic
    always_comb begin
        state_d = BUS_IDLE;
        if (bus_valid) begin
            state_d = size_ok ? BUS_ACK : BUS_REJECT;
        end
    end

    // State register and captured read data
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (bus_valid && !bus_write && size_ok) begin
                rdata_q <= pend_q;
            end else begin
                rdata_q <= '0;
            end
        end
    end

    // Outputs by state
    always_comb begin
        bus_rsp_valid = 1'b0;
        bus_rsp_err   = 1'b0;
        bus_rdata     = '0;
        unique case (state_q)
            BUS_IDLE: begin
                bus_rsp_valid = 1'b0;
            end
            BUS_ACK: begin
                bus_rsp_valid = 1'b1;
                bus_rdata     = rdata_q;
            end
            BUS_REJECT: begin
                bus_rsp_valid = 1'b1;
                bus_rsp_err   = 1'b1;
            end
            default: begin
                bus_rsp_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/eir_regs.sv
module eir_regs
    import ext_irq_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] set_vec,
    input  logic              cpu_we,
    input  logic              cpu_sel,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] pend_q,
    output logic [WORD_W-1:0] mask_q,
    output logic [WORD_W-1:0] pend_d,
    output logic [WORD_W-1:0] mask_d
);
    logic [WORD_W-1:0] clr_vec;

    assign clr_vec = (cpu_we && cpu_sel == SEL_PEND) ? cpu_wdata : '0;

    // Set after clear so a posted interrupt survives a same-cycle acknowledge
    assign pend_d = (pend_q & ~clr_vec) | set_vec;
    assign mask_d = (cpu_we && cpu_sel == SEL_MASK) ? cpu_wdata : mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= pend_d;
            mask_q <= mask_d;
        end
    end

endmodule

// File: rtl/eir_req_gen.sv
module eir_req_gen #(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] pend_d,
    input  logic [WORD_W-1:0] mask_d,
    output logic              irq_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_req <= 1'b0;
        end else begin
            irq_req <= |(pend_d & mask_d);
        end
    end

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
    import ext_irq_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int BUS_DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic              bus_rsp_valid,
    output logic              bus_rsp_err,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              cpu_we,
    input  logic              cpu_sel,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_pend,
    output logic [WORD_W-1:0] cpu_mask,
    output logic              irq_req
);
    logic [WORD_W-1:0] set_vec;
    logic [WORD_W-1:0] pend_q, mask_q, pend_d, mask_d;

    eir_bus_port #(.WORD_W(WORD_W), .BUS_DW(BUS_DW)) u_bus (
        .clk           (clk),
        .rst           (rst),
        .bus_valid     (bus_valid),
        .bus_write     (bus_write),
        .bus_size      (bus_size),
        .bus_wdata     (bus_wdata),
        .pend_q        (pend_q),
        .bus_rsp_valid (bus_rsp_valid),
        .bus_rsp_err   (bus_rsp_err),
        .bus_rdata     (bus_rdata),
        .set_vec       (set_vec)
    );

    eir_regs #(.WORD_W(WORD_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (set_vec),
        .cpu_we    (cpu_we),
        .cpu_sel   (cpu_sel),
        .cpu_wdata (cpu_wdata),
        .pend_q    (pend_q),
        .mask_q    (mask_q),
        .pend_d    (pend_d),
        .mask_d    (mask_d)
    );

    eir_req_gen #(.WORD_W(WORD_W)) u_req (
        .clk     (clk),
        .rst     (rst),
        .pend_d  (pend_d),
        .mask_d  (mask_d),
        .irq_req (irq_req)
    );

    assign cpu_pend = pend_q;
    assign cpu_mask = mask_q;

endmodule

// File: rtl/ext_irq_unit_chk.sv
module ext_irq_unit_chk #(
    parameter int WORD_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [1:0]        bus_size,
    input logic              bus_rsp_valid,
    input logic              bus_rsp_err,
    input logic              cpu_we,
    input logic              cpu_sel,
    input logic [WORD_W-1:0] cpu_wdata,
    input logic [WORD_W-1:0] cpu_pend,
    input logic [WORD_W-1:0] cpu_mask,
    input logic              irq_req
);
    // R8
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_req == |(cpu_pend & cpu_mask)));

    // R3
    bus_no_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && !cpu_we) |=> ((cpu_pend & $past(cpu_pend)) == $past(cpu_pend)));

    // R5
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_size != 2'd2 && !cpu_we) |=> (bus_rsp_err && cpu_pend == $past(cpu_pend)));

    // R10
    rsp_one_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid |=> bus_rsp_valid);

    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> !bus_rsp_valid);

    // R7
    mask_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_sel) |=> (cpu_mask == $past(cpu_wdata)));

endmodule

bind ext_irq_unit ext_irq_unit_chk #(.WORD_W(WORD_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_size      (bus_size),
    .bus_rsp_valid (bus_rsp_valid),
    .bus_rsp_err   (bus_rsp_err),
    .cpu_we        (cpu_we),
    .cpu_sel       (cpu_sel),
    .cpu_wdata     (cpu_wdata),
    .cpu_pend      (cpu_pend),
    .cpu_mask      (cpu_mask),
    .irq_req       (irq_req)
);

// File: tb/ext_irq_unit_tb.sv
module ext_irq_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rsp_valid, bus_rsp_err;
    logic [63:0] bus_rdata;
    logic        cpu_we = 1'b0, cpu_sel = 1'b0;
    logic [63:0] cpu_wdata = '0;
    logic [63:0] cpu_pend, cpu_mask;
    logic        irq_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [63:0] exp_pend = '0;
    logic [63:0] exp_mask = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_unit dut_i (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rsp_valid(bus_rsp_valid),
        .bus_rsp_err(bus_rsp_err), .bus_rdata(bus_rdata),
        .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
        .cpu_pend(cpu_pend), .cpu_mask(cpu_mask), .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle with given stimulus; returns at the following negedge with inputs idle
    task automatic cyc(input logic bv, input logic bw, input logic [1:0] bs, input logic [31:0] bd,
                       input logic we, input logic sel, input logic [63:0] wd);
        bus_valid = bv; bus_write = bw; bus_size = bs; bus_wdata = bd;
        cpu_we = we; cpu_sel = sel; cpu_wdata = wd;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_size = 2'd0; bus_wdata = '0;
        cpu_we = 1'b0; cpu_sel = 1'b0; cpu_wdata = '0;
    endtask

    task automatic check_state(input string req);
        chk(req, cpu_pend, exp_pend);
        chk(req, cpu_mask, exp_mask);
        chk({req, " irq"}, {63'd0, irq_req}, {63'd0, |(exp_pend & exp_mask)});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        exp_pend = '0; exp_mask = '0;
        check_state("R1 reset");
        chk("R10 idle rsp_valid", {63'd0, bus_rsp_valid}, 64'd0);
    endtask

    task automatic t_post_order();
        cyc(1, 1, 2'd2, 32'd0, 0, 0, '0);
        exp_pend[63] = 1'b1;
        chk("R2 num0 -> bit63", cpu_pend, exp_pend);
        chk("R10 write rsp", {62'd0, bus_rsp_valid, bus_rsp_err}, 64'd2);
        cyc(1, 1, 2'd2, 32'd63, 0, 0, '0);
        exp_pend[0] = 1'b1;
        chk("R2 num63 -> bit0", cpu_pend, exp_pend);
        cyc(1, 1, 2'd2, 32'hFFFF_FF05, 0, 0, '0);
        exp_pend[58] = 1'b1;
        chk("R3 high data bits ignored", cpu_pend, exp_pend);
        cyc(1, 1, 2'd2, 32'd5, 0, 0, '0);
        chk("R3 repost keeps others", cpu_pend, exp_pend);
        cyc(0, 0, 2'd0, '0, 0, 0, '0);
        chk("R10 no request no rsp", {63'd0, bus_rsp_valid}, 64'd0);
    endtask

    task automatic t_read();
        cyc(1, 0, 2'd2, '0, 0, 0, '0);
        chk("R4 read data", bus_rdata, exp_pend);
        chk("R4 read rsp", {62'd0, bus_rsp_valid, bus_rsp_err}, 64'd2);
    endtask

    task automatic t_reject();
        cyc(1, 1, 2'd3, 32'd10, 0, 0, '0);
        chk("R5 bad write pend", cpu_pend, exp_pend);
        chk("R5 bad write rsp", {62'd0, bus_rsp_valid, bus_rsp_err}, 64'd3);
        cyc(1, 0, 2'd1, '0, 0, 0, '0);
        chk("R5 bad read rdata", bus_rdata, 64'd0);
        chk("R5 bad read rsp", {62'd0, bus_rsp_valid, bus_rsp_err}, 64'd3);
        cyc(1, 1, 2'd0, 32'd20, 0, 0, '0);
        chk("R5 byte write pend", cpu_pend, exp_pend);
    endtask

    task automatic t_mask_irq();
        chk("R8 irq low mask zero", {63'd0, irq_req}, 64'd0);
        cyc(0, 0, 2'd0, '0, 1, 1, 64'h0000_0000_0000_0001);
        exp_mask = 64'h1;
        check_state("R7 R8 mask enables bit0");
        cyc(0, 0, 2'd0, '0, 1, 1, 64'h0F00_0000_0000_0000);
        exp_mask = 64'h0F00_0000_0000_0000;
        check_state("R7 mask replaced");
        cyc(1, 1, 2'd2, 32'd4, 0, 0, '0);
        exp_pend[59] = 1'b1;
        check_state("R8 irq after bus set");
    endtask

    task automatic t_clear();
        cyc(0, 0, 2'd0, '0, 1, 0, 64'h0C00_0000_0000_0001);
        exp_pend = exp_pend & ~64'h0C00_0000_0000_0001;
        check_state("R6 R8 w1c clear");
        cyc(0, 0, 2'd0, '0, 1, 0, 64'h0);
        check_state("R6 zero write keeps");
    endtask

    task automatic t_collide();
        cyc(1, 1, 2'd2, 32'd6, 1, 0, 64'h0200_0000_0000_0000 | 64'h8000_0000_0000_0000);
        exp_pend[57] = 1'b1;
        exp_pend[63] = 1'b0;
        check_state("R9 set wins");
        cyc(0, 0, 2'd0, '0, 1, 0, '1);
        exp_pend = '0;
        check_state("R6 R8 clear all");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_post_order();
        t_read();
        t_reject();
        t_mask_irq();
        t_clear();
        t_collide();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule